// File: doc/BRIEF.md
# M/N Fractional Clock-Enable Divider

This block turns a free-running reference clock into a stream of one-cycle enable pulses whose average rate is the reference rate scaled by a programmable fraction M/N. A downstream serial engine gates its work on these pulses instead of on a derived clock. Thus the whole design stays in one clock domain, and no clock multiplexer or PLL is needed.

Software controls the divider through a single control word. One write can set the enable, stage new values of M and N and request that the staged values be loaded. Staged values have no effect on the pulse train until a load is requested. A load restarts the fractional phase from zero. When M equals N, when M exceeds N, or when N is zero, the divider passes every reference cycle through as a pulse. Software is expected to allow a short settling interval after a load before it relies on the new rate.

Top module: `mn_frac_div`

## Requirements
- R1: After reset `tick_o` is 0 and `rd_data` reads all zeros.
- R2: A write stores the control word, and `rd_data` shows it from the next cycle on. The bit positions are: bit 0 is the enable, bits 15:1 are M, bits 30:16 are N and bit 31 is the load request.
- R3: A write with bit 31 set makes `rd_data[31]` read 1 in the next cycle. It reads 0 in the cycle after that, once the staged M and N are active.
- R4: A write with bit 31 clear does not change the active M and N. The pulse pattern continues at the old ratio.
- R5: While the stored enable bit is 0, `tick_o` stays 0 and the phase accumulator is held at zero. A later enable therefore starts from a clean phase.
- R6: With the enable set and 0 < M < N, each reference step adds M to an accumulator that starts at zero. When the sum is N or more, N is subtracted and `tick_o` pulses one cycle later. Otherwise the sum is kept and `tick_o` stays 0.
- R7: With M equal to N and the enable set, `tick_o` is 1 on every cycle.
- R8: With M greater than N, or with N equal to 0, the divider acts as a pass-through: `tick_o` is 1 on every cycle while the enable is set.
- R9: The cycle in which staged values are loaded produces no pulse, and the accumulator restarts from zero. The first step at the new ratio shows on `tick_o` two cycles after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: {load, N, M, enable} |
| rd_data | output | 32 | Control word readback; bit 31 shows a pending load |
| tick_o | output | 1 | Clock-enable pulse train at the reference rate times M/N |

## Verification
A wrong accumulator value shows at `tick_o` as a pulse that comes early or late. The error appears in the first step where the true sum and the corrupted sum fall on opposite sides of N. At the latest it is visible within N cycles, because every ratio pattern repeats with period N. A stuck load request or stale active ratio shows in two ways: `rd_data[31]` does not fall one cycle after being set, and the pulse pattern keeps the old ratio from the second cycle after the write. An enable that fails to clear the phase shows as a pulse in the wrong step right after the divider is enabled again.

// File: rtl/mn_div_pkg.sv
package mn_div_pkg;
  localparam int unsigned DEF_FIELD_W = 15;

  typedef enum logic [1:0] {
    STEP_OFF  = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_PASS = 2'd2,
    STEP_FRAC = 2'd3
  } step_mode_e;
endpackage

// File: rtl/mn_ctl_reg.sv
module mn_ctl_reg #(
  parameter int unsigned FW = mn_div_pkg::DEF_FIELD_W,
  localparam int unsigned CW = 2*FW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic [FW-1:0] stg_m,
  output logic [FW-1:0] stg_n,
  output logic          en_o,
  output logic          load_o
);
  localparam int unsigned M_LO = 1;
  localparam int unsigned N_LO = FW + 1;
  localparam int unsigned UPD  = CW - 1;

  logic [FW-1:0] m_q, m_d, n_q, n_d;
  logic          en_q, en_d, pend_q, pend_d;

  always_comb begin
    m_d    = m_q;
    n_d    = n_q;
    en_d   = en_q;
    pend_d = 1'b0;
    if (wr_en) begin
      m_d    = wr_data[M_LO +: FW];
      n_d    = wr_data[N_LO +: FW];
      en_d   = wr_data[0];
      pend_d = wr_data[UPD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q    <= '0;
      n_q    <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      m_q    <= m_d;
      n_q    <= n_d;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign rd_data = {pend_q, n_q, m_q, en_q};
  assign stg_m   = m_q;
  assign stg_n   = n_q;
  assign en_o    = en_q;
  assign load_o  = pend_q;
endmodule

// File: rtl/mn_ratio_load.sv
module mn_ratio_load #(
  parameter int unsigned FW = mn_div_pkg::DEF_FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [FW-1:0] stg_m,
  input  logic [FW-1:0] stg_n,
  output logic [FW-1:0] act_m,
  output logic [FW-1:0] act_n,
  output logic          pass_o
);
  logic [FW-1:0] am_q, am_d, an_q, an_d;

  always_comb begin
    am_d = am_q;
    an_d = an_q;
    if (load_i) begin
      am_d = stg_m;
      an_d = stg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      am_q <= '0;
      an_q <= '0;
    end else begin
      am_q <= am_d;
      an_q <= an_d;
    end
  end

  assign act_m  = am_q;
  assign act_n  = an_q;
  assign pass_o = (an_q == '0) || (am_q >= an_q);
endmodule

// File: rtl/mn_accum.sv
module mn_accum
  import mn_div_pkg::*;
#(
  parameter int unsigned FW = DEF_FIELD_W,
  localparam int unsigned AW = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          pass_i,
  input  logic [FW-1:0] act_m,
  input  logic [FW-1:0] act_n,
  output logic          tick_o
);
  step_mode_e    mode;
  logic [AW-1:0] sum;
  logic [FW-1:0] acc_q, acc_d;
  logic          tick_q, tick_d;

  always_comb begin
    if (load_i)      mode = STEP_LOAD;
    else if (!en_i)  mode = STEP_OFF;
    else if (pass_i) mode = STEP_PASS;
    else             mode = STEP_FRAC;
  end

  assign sum = {1'b0, acc_q} + {1'b0, act_m};

  always_comb begin
    acc_d  = '0;
    tick_d = 1'b0;
    case (mode)
      STEP_PASS: tick_d = 1'b1;
      STEP_FRAC: begin
        if (sum >= {1'b0, act_n}) begin
          acc_d  = FW'(sum - {1'b0, act_n});
          tick_d = 1'b1;
        end else begin
          acc_d  = FW'(sum);
        end
      end
      default: begin
        acc_d  = '0;
        tick_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/mn_frac_div.sv
module mn_frac_div #(
  parameter int unsigned FIELD_W = mn_div_pkg::DEF_FIELD_W,
  localparam int unsigned CW = 2*FIELD_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic          tick_o
);
  logic                rst_s1, rst_sync_n;
  logic [FIELD_W-1:0]  stg_m, stg_n, act_m, act_n;
  logic                en, load, pass;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  mn_ctl_reg #(.FW(FIELD_W)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .stg_m(stg_m), .stg_n(stg_n), .en_o(en), .load_o(load)
  );

  mn_ratio_load #(.FW(FIELD_W)) u_load (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load), .stg_m(stg_m), .stg_n(stg_n),
    .act_m(act_m), .act_n(act_n), .pass_o(pass)
  );

  mn_accum #(.FW(FIELD_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .en_i(en), .load_i(load), .pass_i(pass),
    .act_m(act_m), .act_n(act_n), .tick_o(tick_o)
  );
endmodule

// File: rtl/mn_frac_div_chk.sv
module mn_frac_div_chk #(
  parameter int unsigned FW = mn_div_pkg::DEF_FIELD_W,
  localparam int unsigned CW = 2*FW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] rd_data,
  input logic          tick_o,
  input logic [FW-1:0] act_m,
  input logic [FW-1:0] act_n
);
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[CW-2:0] == $past(wr_data[CW-2:0]));

  a_r3_load_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CW-1]) |=> rd_data[CW-1]);

  a_r3_load_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[CW-1] && !(wr_en && wr_data[CW-1])) |=> !rd_data[CW-1]);

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |=> !tick_o);

  a_r9_load_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CW-1] |=> !tick_o);

  // R7 and R8: ratio at or above one, or zero divisor, passes every cycle
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !rd_data[CW-1] && ((act_n == '0) || (act_m >= act_n)))
      |=> tick_o);
endmodule

bind mn_frac_div mn_frac_div_chk #(.FW(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tick_o(tick_o), .act_m(act_m), .act_n(act_n)
);

// File: tb/mn_frac_div_test.sv
`timescale 1ns/1ps
module mn_frac_div_test;
  localparam time TCK = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit    q_exp[$];
  string q_tag[$];

  // reference model state, built from the requirements
  int mdl_m = 0, mdl_n = 0, mdl_acc = 0;
  bit mdl_en = 0;

  mn_frac_div uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_o(tick_o)
  );

  always #(TCK/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit mdl_step();
    bit t = 0;
    if (!mdl_en) begin
      mdl_acc = 0;
    end else if (mdl_n == 0 || mdl_m >= mdl_n) begin
      mdl_acc = 0;
      t = 1;
    end else begin
      mdl_acc += mdl_m;
      if (mdl_acc >= mdl_n) begin
        mdl_acc -= mdl_n;
        t = 1;
      end
    end
    return t;
  endfunction

  // monitor: samples 1 ns after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (q_exp.size() > 0) begin
      bit    e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(tick_o == e, t, "tick_o", tick_o, e);
    end
  end

  task automatic prog(input int m, input int n, input bit en, input bit upd,
                      input int len, input string tag);
    logic [31:0] w;
    bit          hidden;
    w = {upd, n[14:0], m[14:0], en};
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(posedge clk);
    hidden = mdl_step();  // step at the write edge, old settings
    mdl_en = en;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data[30:0] == w[30:0], "R2", "rd_data fields", rd_data[30:0], w[30:0]);
    check(rd_data[31] == upd, "R3", "load flag after write", rd_data[31], upd);
    if (upd) begin
      mdl_m = m;
      mdl_n = n;
      mdl_acc = 0;
      @(negedge clk);
      check(rd_data[31] == 1'b0, "R3", "load flag cleared", rd_data[31], 0);
      check(tick_o == 1'b0, "R9", "tick in load cycle", tick_o, 0);
    end
    for (int i = 0; i < len; i++) begin
      q_exp.push_back(mdl_step());
      q_tag.push_back(tag);
    end
    while (q_exp.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tick_o == 1'b0, "R1", "tick_o after reset", tick_o, 0);
    check(rd_data == 32'h0, "R1", "rd_data after reset", rd_data, 0);

    prog(1, 1, 1, 1, 8, "R7");     // equal M and N
    prog(1, 4, 1, 0, 8, "R4");     // staged only: still every cycle
    prog(1, 4, 1, 1, 16, "R6");    // now loaded: one in four
    prog(2, 5, 1, 1, 20, "R6");
    prog(3, 7, 1, 1, 14, "R6");
    prog(9, 4, 1, 1, 6, "R8");     // M above N
    prog(5, 0, 1, 1, 6, "R8");     // zero divisor
    prog(1, 3, 0, 1, 10, "R5");    // disabled: no pulses
    prog(1, 3, 1, 0, 9, "R6");     // enable without load
    prog(1, 2, 1, 1, 4, "R6");     // leaves phase at one after write edge
    prog(1, 2, 0, 0, 6, "R5");     // disable clears phase
    prog(1, 2, 1, 0, 6, "R5");     // restart from zero phase
    prog(7, 7, 1, 1, 5, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule